// File: doc/BRIEF.md
# Per-Bit Configurable I/O Port with Pattern Interrupt

This block is a general-purpose parallel port. A CPU sets each of its lines to be an input or an output, one bit at a time. There is no data handshaking. A write to the port updates only the lines that are set as outputs. A read returns the live pin level on input lines and the latched value on output lines. Two further lines, a strobe-side line and a ready-side line, are set up through the control byte and work as plain I/O bits.

A masked pattern detector drives a level-sensitive interrupt. The CPU chooses which port lines take part and which reduction applies to them: AND, OR, NAND or NOR. For an input line the detector uses the pin level, and for an output line it uses the latched value. The two auxiliary lines never take part. The CPU interface is a simple synchronous bus with a two-bit offset. A read returns its data one cycle after the request.

Top module: `bpio_port`

## Requirements
- R1: While and after reset, all port lines and both auxiliary lines are inputs (pin_oe=0, aux_oe=0). The output latch, the mask and the control byte are zero, and irq is low.
- R2: A write to offset 1 sets the direction register (bit=1 makes the line an output). pin_oe shows it from the cycle after the write.
- R3: A write to offset 0 loads wr_data only into the latch bits whose line is an output. Latch bits of input lines keep their previous value, which appears on pin_out once the line is made an output.
- R4: A read raises cpu_rvalid on the next cycle. For offset 0, cpu_rdata then holds pin_in for input lines and the latch for output lines, sampled in the request cycle.
- R5: Offset 2 is the interrupt mask. Unmasked lines are forced to 1 for AND/NAND and to 0 for OR/NOR, so an empty mask makes AND and NOR true and makes OR and NAND false. For an output line the detector uses its latch, not pin_in.
- R6: Control bits [1:0] select the reduction: 00 AND, 01 OR, 10 NAND, 11 NOR.
- R7: When control bit 2 (enable) is set, irq is high in the cycle after the condition holds, stays high while it holds, and falls in the cycle after the condition ends or enable is cleared.
- R8: Control bits [5:4] set the direction of the strobe-side (bit 4) and ready-side (bit 5) lines, and bits [7:6] are their output latch. A read of offset 3 returns bits [5:0] as written (bit 3 always reads 0), and bits [7:6] with aux_in substituted for lines set as inputs.
- R9: The auxiliary lines have no effect on irq.
- R10: Offsets 1 and 2 read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 2 | Register offset |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | PORT_W | Write data |
| cpu_rd | input | 1 | Read request |
| cpu_rdata | output | PORT_W | Read data, registered |
| cpu_rvalid | output | 1 | Read data valid |
| pin_in | input | PORT_W | Port pin levels |
| pin_out | output | PORT_W | Port output latch |
| pin_oe | output | PORT_W | Port output enables |
| aux_in | input | 2 | Auxiliary line levels |
| aux_out | output | 2 | Auxiliary output latch |
| aux_oe | output | 2 | Auxiliary output enables |
| irq | output | 1 | Pattern interrupt, level |

## Verification
The detector is exercised with each reduction code against three kinds of pin pattern. One pattern has all selected lines true, one has a single selected line flipped, and one changes only unselected lines, which shows whether the mask forcing is correct. An empty mask shows the identity values under AND and OR. A case in which only an output latch satisfies OR, while the pins say otherwise, separates latch-fed lines from pin-fed lines. Direction sequences that write data while a line is an input, then make it an output, show whether the hidden latch bits were kept.

// File: rtl/bpio_pkg.sv
package bpio_pkg;
  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_DIR  = 2'd1;
  localparam logic [1:0] OFS_MASK = 2'd2;
  localparam logic [1:0] OFS_CTRL = 2'd3;
  localparam int AUX_W = 2;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NAND = 2'b10,
    FN_NOR  = 2'b11
  } match_fn_e;

  typedef struct packed {
    logic [AUX_W-1:0] aux_val;
    logic [AUX_W-1:0] aux_dir;
    logic             rsvd;
    logic             irq_en;
    match_fn_e        fn;
  } ctrl_t;
endpackage

// File: rtl/bpio_regs.sv
module bpio_regs
  import bpio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] mask_q,
  output ctrl_t             ctrl_q
);
  ctrl_t ctrl_wr;

  always_comb begin
    ctrl_wr      = ctrl_t'(wr_data[7:0]);
    ctrl_wr.rsvd = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      latch_q <= '0;
      mask_q  <= '0;
      ctrl_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_DATA: latch_q <= (latch_q & ~dir_q) | (wr_data & dir_q);
        OFS_DIR:  dir_q   <= wr_data;
        OFS_MASK: mask_q  <= wr_data;
        default:  ctrl_q  <= ctrl_wr;
      endcase
    end
  end
endmodule

// File: rtl/bpio_match.sv
module bpio_match
  import bpio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic [PORT_W-1:0] lines,
  input  logic [PORT_W-1:0] mask,
  input  match_fn_e         fn,
  output logic              hit
);
  logic [PORT_W-1:0] and_term;
  logic [PORT_W-1:0] or_term;

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    assign and_term[i] = mask[i] ? lines[i] : 1'b1;
    assign or_term[i]  = mask[i] & lines[i];
  end

  logic all_set;
  logic any_set;
  assign all_set = &and_term;
  assign any_set = |or_term;

  always_comb begin
    case (fn)
      FN_AND:  hit = all_set;
      FN_OR:   hit = any_set;
      FN_NAND: hit = ~all_set;
      default: hit = ~any_set;
    endcase
  end
endmodule

// File: rtl/bpio_readmux.sv
module bpio_readmux
  import bpio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] line_val,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] mask_q,
  input  ctrl_t             ctrl_q,
  input  logic [AUX_W-1:0]  aux_in,
  output logic [PORT_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int PAD_W = PORT_W - 8;

  logic [AUX_W-1:0]  aux_merged;
  logic [PORT_W-1:0] ctrl_view;
  logic [PORT_W-1:0] sel;

  assign aux_merged = (aux_in & ~ctrl_q.aux_dir) | (ctrl_q.aux_val & ctrl_q.aux_dir);

  if (PAD_W > 0) begin : g_pad
    assign ctrl_view = {{PAD_W{1'b0}}, aux_merged, ctrl_q[5:0]};
  end else begin : g_nopad
    assign ctrl_view = {aux_merged, ctrl_q[5:0]};
  end

  always_comb begin
    case (addr)
      OFS_DATA: sel = line_val;
      OFS_DIR:  sel = dir_q;
      OFS_MASK: sel = mask_q;
      default:  sel = ctrl_view;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end
endmodule

// File: rtl/bpio_port.sv
module bpio_port
  import bpio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cpu_addr,
  input  logic              cpu_wr,
  input  logic [PORT_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  output logic [PORT_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  input  logic [1:0]        aux_in,
  output logic [1:0]        aux_out,
  output logic [1:0]        aux_oe,
  output logic              irq
);
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] latch_q;
  logic [PORT_W-1:0] mask_q;
  ctrl_t             ctrl_q;
  logic [PORT_W-1:0] line_val;
  logic              hit;
  logic              irq_q;

  bpio_regs #(.PORT_W(PORT_W)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cpu_wr),
    .addr    (cpu_addr),
    .wr_data (cpu_wdata),
    .dir_q   (dir_q),
    .latch_q (latch_q),
    .mask_q  (mask_q),
    .ctrl_q  (ctrl_q)
  );

  // inputs follow the pins, outputs follow the latch
  assign line_val = (pin_in & ~dir_q) | (latch_q & dir_q);

  bpio_match #(.PORT_W(PORT_W)) match_i (
    .lines (line_val),
    .mask  (mask_q),
    .fn    (ctrl_q.fn),
    .hit   (hit)
  );

  bpio_readmux #(.PORT_W(PORT_W)) rmux_i (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (cpu_rd),
    .addr     (cpu_addr),
    .line_val (line_val),
    .dir_q    (dir_q),
    .mask_q   (mask_q),
    .ctrl_q   (ctrl_q),
    .aux_in   (aux_in),
    .rd_data  (cpu_rdata),
    .rd_valid (cpu_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ctrl_q.irq_en & hit;
  end

  assign irq     = irq_q;
  assign pin_out = latch_q;
  assign pin_oe  = dir_q;
  assign aux_out = ctrl_q.aux_val;
  assign aux_oe  = ctrl_q.aux_dir;
endmodule

// File: rtl/bpio_port_chk.sv
module bpio_port_chk
  import bpio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cpu_addr,
  input logic              cpu_wr,
  input logic [PORT_W-1:0] cpu_wdata,
  input logic              cpu_rd,
  input logic              cpu_rvalid,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pin_oe,
  input logic [1:0]        aux_oe,
  input logic              irq
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && aux_oe == '0 && !irq));

  a_r2_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !(cpu_wr && cpu_addr == OFS_DIR) |=> $stable(pin_oe));

  a_r3_inputs_keep: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == OFS_DATA) |=>
      ((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0);

  a_r3_outputs_take: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == OFS_DATA) |=>
      (pin_out & $past(pin_oe)) == ($past(cpu_wdata) & $past(pin_oe)));

  a_r4_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    cpu_rd |=> cpu_rvalid);

  a_r4_rvalid_quiet: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> !cpu_rvalid);

  a_r7_disable_drops: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == OFS_CTRL && !cpu_wdata[2]) |-> ##2 !irq);

  a_r8_aux_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !(cpu_wr && cpu_addr == OFS_CTRL) |=> $stable(aux_oe));
endmodule

bind bpio_port bpio_port_chk #(.PORT_W(PORT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cpu_addr   (cpu_addr),
  .cpu_wr     (cpu_wr),
  .cpu_wdata  (cpu_wdata),
  .cpu_rd     (cpu_rd),
  .cpu_rvalid (cpu_rvalid),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .aux_oe     (aux_oe),
  .irq        (irq)
);

// File: tb/bpio_port_tb_top.sv
`timescale 1ns/1ps
module bpio_port_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   cpu_addr = '0;
  logic         cpu_wr = 1'b0;
  logic [W-1:0] cpu_wdata = '0;
  logic         cpu_rd = 1'b0;
  logic [W-1:0] cpu_rdata;
  logic         cpu_rvalid;
  logic [W-1:0] pin_in = 8'hA5;
  logic [W-1:0] pin_out;
  logic [W-1:0] pin_oe;
  logic [1:0]   aux_in = 2'b00;
  logic [1:0]   aux_out;
  logic [1:0]   aux_oe;
  logic         irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2.5 clk = ~clk;

  bpio_port #(.PORT_W(W)) dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .cpu_rvalid(cpu_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .aux_in(aux_in), .aux_out(aux_out),
    .aux_oe(aux_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  // driver: queue the expected read data, monitor compares it
  task automatic rd(input logic [1:0] a, input logic [W-1:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (cpu_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, cpu_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pin_oe in reset", pin_oe, 0);
    check("R1 irq in reset", irq, 0);
    rst = 1'b0;
    step();
    check("R1 pin_oe", pin_oe, 0);
    check("R1 pin_out", pin_out, 0);
    check("R1 aux_oe", aux_oe, 0);
    check("R1 irq", irq, 0);
    rd(2'd0, 8'hA5, "R4 all-input read of pins");
    rd(2'd2, 8'h00, "R1 mask reset");
    rd(2'd3, 8'h00, "R1 control reset");

    // R2 / R10: direction
    wr(2'd1, 8'h0F);
    check("R2 pin_oe follows direction", pin_oe, 8'h0F);
    rd(2'd1, 8'h0F, "R10 direction readback");

    // R3 / R4: partial write and merged read
    wr(2'd0, 8'hFF);
    check("R3 only output bits latched", pin_out, 8'h0F);
    pin_in = 8'h30;
    rd(2'd0, 8'h3F, "R4 merged read");
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'h00);
    check("R3 input-line latch bits kept", pin_out, 8'h0F);
    wr(2'd1, 8'hFF);
    check("R3 hidden latch appears on output", pin_out, 8'h0F);
    rd(2'd0, 8'h0F, "R4 pins ignored on output lines");

    // interrupt reductions, all lines inputs, mask low nibble
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h0F);
    rd(2'd2, 8'h0F, "R10 mask readback");
    wr(2'd3, 8'h04);                      // AND, enabled
    pin_in = 8'h0E; step();
    check("R6 AND one line low", irq, 0);
    pin_in = 8'h0F; step();
    check("R7 AND asserts next cycle", irq, 1);
    step();
    check("R7 level held", irq, 1);
    pin_in = 8'hF7; step();
    check("R5 AND unmasked highs ignored", irq, 0);

    wr(2'd3, 8'h05);                      // OR
    pin_in = 8'hF0; step();
    check("R5 OR unmasked lines ignored", irq, 0);
    pin_in = 8'h02; step();
    check("R6 OR one line high", irq, 1);

    wr(2'd3, 8'h06);                      // NAND
    pin_in = 8'h0F; step();
    check("R6 NAND all high", irq, 0);
    pin_in = 8'h0B; step();
    check("R6 NAND one low", irq, 1);

    wr(2'd3, 8'h07);                      // NOR
    pin_in = 8'h00; step();
    check("R6 NOR all low", irq, 1);
    pin_in = 8'hF0; step();
    check("R5 NOR unmasked highs ignored", irq, 1);
    pin_in = 8'h08; step();
    check("R6 NOR one high", irq, 0);

    // R7: disable drops irq
    pin_in = 8'h00; step();
    check("R7 NOR asserted before disable", irq, 1);
    wr(2'd3, 8'h03);
    step();
    check("R7 disable deasserts", irq, 0);

    // R5: empty mask identities
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h04);
    step();
    check("R5 empty mask AND true", irq, 1);
    wr(2'd3, 8'h05);
    step();
    check("R5 empty mask OR false", irq, 0);

    // R5: output line uses latch, not pin
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h00);
    pin_in = 8'hFF; step();
    check("R5 output line latch low, pin ignored", irq, 0);
    wr(2'd0, 8'h01);
    pin_in = 8'h00; step();
    check("R5 output line latch high drives OR", irq, 1);

    // R8 / R9: auxiliary lines
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h55);                      // OR, en, strobe-side out=1
    check("R8 aux_oe", aux_oe, 2'b01);
    check("R8 aux_out", aux_out, 2'b01);
    aux_in = 2'b11;
    rd(2'd3, 8'hD5, "R8 control read merges aux_in");
    step();
    check("R9 aux lines do not raise irq", irq, 0);
    wr(2'd3, 8'h5D);                      // bit 3 set, reads back 0
    aux_in = 2'b00;
    rd(2'd3, 8'h55, "R8 reserved bit reads zero");
    step();
    check("R9 irq still low", irq, 0);

    repeat (3) step();
    check("R4 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule